// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is a synthesizable model of a serial EEPROM target that listens on a chip-select, a serial clock and a data-in line. It keeps a 16-kbit array in on-chip registers. A mode input sets the word size to either 16 bits (1024 words) or 8 bits (2048 bytes). The data-out pin is tri-state, so it is modelled as a data bit plus an output enable. All three serial inputs are sampled by a faster system clock through two-stage synchronizers. Every action happens on a detected rising edge of the serial clock.

A host sends a frame while chip-select is high: a start bit, a two-bit opcode, the address, and the data for commands that take data. Reads return a dummy zero first, then the word with its most significant bit first. If chip-select stays high, reading continues through the following words. Programming commands only take effect after an unlock command, and only while the protect input is high. Each one starts a self-timed busy period whose length in system clocks is a parameter. The host polls that period on the data-out pin.

Top module: `uwire_eeprom`

## Requirements
- R1: A frame begins at the first serial-clock rising edge that sees chip-select and data-in both high. Rising edges with data-in low before that edge are ignored. Serial-clock activity while chip-select is low changes nothing.
- R2: After the start bit, the next two bits are the opcode: 10 read, 01 write, 11 erase, 00 extended. For the extended opcode, the two most significant address bits select the command: 11 unlock, 10 erase-all, 01 write-all, 00 lock. The other address bits are ignored.
- R3: With `orgWide` high, a frame carries a WORD_AW-bit address and 16-bit data. With `orgWide` low, it carries a (WORD_AW+1)-bit address and 8-bit data. In 8-bit mode, byte 2n is bits 7:0 of 16-bit word n and byte 2n+1 is bits 15:8.
- R4: After reset, writing is locked. Write, erase, erase-all and write-all then have no effect and show no status until an unlock command arrives. Writing stays unlocked until a lock command. Reads work in either state.
- R5: While `progEnable` is low, every programming command has no effect and shows no status.
- R6: Erase sets the addressed word (or byte, in 8-bit mode) to all ones. Write stores the received data at the address.
- R7: Erase-all sets every bit of the array to one. Write-all leaves every word equal to the received data; in 8-bit mode the byte is repeated in both halves of each word.
- R8: A frame that loses chip-select before its last address or data bit is discarded.
- R9: After the last address bit of a read, DO is driven with 0. The word bits then follow, most significant first, one per serial-clock rising edge.
- R10: While chip-select stays high after a read word, the address increments and the next word follows at once, with no dummy zero. The address wraps from the last word to word 0.
- R11: `doOe` is low except during read output or status. After a programming command, raising chip-select drives DO with 0 while busy and 1 when ready. DO is released when chip-select falls. A start bit given once ready, followed by chip-select low, clears the status.
- R12: A programming command is busy for PROG_CYCLES system clocks (BULK_CYCLES for erase-all and write-all). While busy, start bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, active high |
| sclkIn | input | 1 | Serial clock |
| diIn | input | 1 | Serial data in |
| orgWide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| progEnable | input | 1 | Programming allowed when high |
| doOut | output | 1 | Serial data out value |
| doOe | output | 1 | Output enable for doOut (0 means high-Z) |

## Verification
Most internal faults in this block show up on DO within a frame or one busy period:
- An opcode or bit counter that slips by one shifts every read word. It also misplaces the dummy zero on the first data edge after the address.
- A stuck write-enable latch or protect gate shows as a status reply where none should appear, or a missing one, as soon as chip-select is raised again.
- A wrong busy-counter load changes how long the polled DO stays low, by hundreds of system clocks.
- A broken auto-increment or wrap appears on the first word boundary of a sequential read that crosses the end of the array.

The bench sweeps every word of a small array in both organizations and compares against an arithmetic pattern.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPCODE,
    PH_ADDR,
    PH_DATA,
    PH_READ,
    PH_DONE
  } phase_t;

  // strobes from control to datapath, each valid for one system clock
  typedef struct packed {
    logic addrShift;
    logic dataShift;
    logic rdStart;
    logic rdStep;
    logic wrWord;
    logic eraseWord;
    logic eraseAll;
    logic writeAll;
  } dpCmd_t;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_CLEAR  = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/uwire_ctrl.sv
module uwire_ctrl
  import uwire_pkg::*;
#(
  parameter int WORD_AW     = 10,
  parameter int PROG_CYCLES = 5000,
  parameter int BULK_CYCLES = 15000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   csIn,
  input  logic   sclkIn,
  input  logic   diIn,
  input  logic   orgWide,
  input  logic   progEnable,
  output dpCmd_t cmd,
  output logic   diBit,
  output logic   doOe,
  output logic   statusSel,
  output logic   busy,
  output logic   writeEnabled,
  output phase_t phase
);

  // WORD_AW must be at least 3 so the extended code is captured before the last address bit
  localparam int CNT_W  = $clog2(WORD_AW + 17);
  localparam int BUSY_W = $clog2(((BULK_CYCLES > PROG_CYCLES) ? BULK_CYCLES : PROG_CYCLES) + 1);
  localparam logic [CNT_W-1:0] ONE_C     = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_A16  = CNT_W'(WORD_AW - 1);
  localparam logic [CNT_W-1:0] LAST_A8   = CNT_W'(WORD_AW);
  localparam logic [CNT_W-1:0] LAST_D16  = CNT_W'(15);
  localparam logic [CNT_W-1:0] LAST_D8   = CNT_W'(7);
  localparam logic [BUSY_W-1:0] PROG_LD  = BUSY_W'(PROG_CYCLES);
  localparam logic [BUSY_W-1:0] BULK_LD  = BUSY_W'(BULK_CYCLES);
  localparam logic [BUSY_W-1:0] ONE_B    = BUSY_W'(1);

  logic [1:0]        csSync, diSync;
  logic [2:0]        sclkSync;
  logic              csS, sclkRise;
  logic [CNT_W-1:0]  bitCnt;
  logic [1:0]        opc, ext;
  logic              welQ, showStat;
  logic [BUSY_W-1:0] busyCnt;
  logic              addrDone, dataDone, progOk;

  assign csS      = csSync[1];
  assign diBit    = diSync[1];
  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign busy     = (busyCnt != '0);
  assign progOk   = welQ && progEnable;
  assign addrDone = (bitCnt == (orgWide ? LAST_A16 : LAST_A8));
  assign dataDone = (bitCnt == (orgWide ? LAST_D16 : LAST_D8));

  assign writeEnabled = welQ;
  assign statusSel    = showStat && (phase == PH_IDLE);
  assign doOe         = csS && ((phase == PH_READ) || statusSel);

  always_comb begin
    cmd = '0;
    if (csS && sclkRise) begin
      case (phase)
        PH_ADDR: begin
          cmd.addrShift = 1'b1;
          if (addrDone) begin
            cmd.rdStart   = (opc == OPC_READ);
            cmd.eraseWord = (opc == OPC_ERASE) && progOk;
            cmd.eraseAll  = (opc == OPC_EXT) && (ext == EXT_CLEAR) && progOk;
          end
        end
        PH_DATA: begin
          cmd.dataShift = 1'b1;
          if (dataDone) begin
            cmd.wrWord   = (opc == OPC_WRITE) && progOk;
            cmd.writeAll = (opc == OPC_EXT) && progOk;
          end
        end
        PH_READ: cmd.rdStep = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSync   <= '0;
      diSync   <= '0;
      sclkSync <= '0;
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      opc      <= '0;
      ext      <= '0;
      welQ     <= 1'b0;
      showStat <= 1'b0;
      busyCnt  <= '0;
    end else begin
      csSync   <= {csSync[0], csIn};
      diSync   <= {diSync[0], diIn};
      sclkSync <= {sclkSync[1:0], sclkIn};

      if (!csS) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
      end else if (sclkRise) begin
        case (phase)
          PH_IDLE: begin
            if (diBit && !busy) begin
              phase    <= PH_OPCODE;
              bitCnt   <= '0;
              showStat <= 1'b0;
            end
          end
          PH_OPCODE: begin
            opc <= {opc[0], diBit};
            if (bitCnt == ONE_C) begin
              phase  <= PH_ADDR;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + ONE_C;
            end
          end
          PH_ADDR: begin
            if (bitCnt == '0)   ext[1] <= diBit;
            if (bitCnt == ONE_C) ext[0] <= diBit;
            if (addrDone) begin
              bitCnt <= '0;
              case (opc)
                OPC_READ:  phase <= PH_READ;
                OPC_WRITE: phase <= PH_DATA;
                OPC_ERASE: phase <= PH_DONE;
                default: begin
                  phase <= (ext == EXT_FILL) ? PH_DATA : PH_DONE;
                  if (ext == EXT_UNLOCK) welQ <= 1'b1;
                  if (ext == EXT_LOCK)   welQ <= 1'b0;
                end
              endcase
            end else begin
              bitCnt <= bitCnt + ONE_C;
            end
          end
          PH_DATA: begin
            if (dataDone) begin
              phase  <= PH_DONE;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + ONE_C;
            end
          end
          default: ;
        endcase
      end

      if (cmd.eraseWord || cmd.wrWord) begin
        busyCnt  <= PROG_LD;
        showStat <= 1'b1;
      end else if (cmd.eraseAll || cmd.writeAll) begin
        busyCnt  <= BULK_LD;
        showStat <= 1'b1;
      end else if (busy) begin
        busyCnt <= busyCnt - ONE_B;
      end
    end
  end

endmodule

// File: rtl/uwire_dp.sv
module uwire_dp
  import uwire_pkg::*;
#(
  parameter int WORD_AW = 10
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   orgWide,
  input  logic   diBit,
  input  dpCmd_t cmd,
  output logic   rdBit
);

  localparam int WORDS = 1 << WORD_AW;
  localparam logic [WORD_AW-1:0] ONE_W = WORD_AW'(1);
  localparam logic [WORD_AW:0]   ONE_B = (WORD_AW + 1)'(1);

  logic [15:0]        mem [WORDS];
  logic [WORD_AW:0]   addrQ, addrNext, addrInc;
  logic [14:0]        dataQ;
  logic [15:0]        dataNext, fillWord;
  logic [15:0]        shQ, curWord, aligned;
  logic [3:0]         rdCnt, wordLast;
  logic [WORD_AW-1:0] curIdx, finIdx;
  logic               finLane;

  // in 8-bit mode the low address bit selects the byte lane (1 = upper half)
  function automatic logic [WORD_AW-1:0] wordIdx(input logic [WORD_AW:0] a, input logic wide);
    return wide ? a[WORD_AW-1:0] : a[WORD_AW:1];
  endfunction

  assign addrNext = {addrQ[WORD_AW-1:0], diBit};
  assign dataNext = {dataQ, diBit};
  assign fillWord = orgWide ? dataNext : {dataNext[7:0], dataNext[7:0]};
  assign wordLast = orgWide ? 4'd15 : 4'd7;
  assign addrInc  = orgWide ? {1'b0, addrQ[WORD_AW-1:0] + ONE_W} : addrQ + ONE_B;

  assign curIdx  = wordIdx(addrQ, orgWide);
  assign curWord = mem[curIdx];
  assign aligned = orgWide ? curWord
                           : {(addrQ[0] ? curWord[15:8] : curWord[7:0]), 8'h00};

  // erase completes on the last address bit, so it uses the address still arriving
  assign finIdx  = cmd.eraseWord ? wordIdx(addrNext, orgWide) : curIdx;
  assign finLane = cmd.eraseWord ? addrNext[0] : addrQ[0];

  always_ff @(posedge clk) begin
    if (cmd.eraseAll || cmd.writeAll) begin
      for (int i = 0; i < WORDS; i++) begin
        mem[i] <= cmd.eraseAll ? 16'hFFFF : fillWord;
      end
    end else if (cmd.eraseWord || cmd.wrWord) begin
      if (orgWide) begin
        mem[finIdx] <= cmd.eraseWord ? 16'hFFFF : dataNext;
      end else if (finLane) begin
        mem[finIdx][15:8] <= cmd.eraseWord ? 8'hFF : dataNext[7:0];
      end else begin
        mem[finIdx][7:0] <= cmd.eraseWord ? 8'hFF : dataNext[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      shQ   <= '0;
      rdCnt <= '0;
      rdBit <= 1'b0;
    end else begin
      if (cmd.addrShift) addrQ <= addrNext;
      if (cmd.dataShift) dataQ <= dataNext[14:0];
      if (cmd.rdStart) begin
        rdBit <= 1'b0;
        rdCnt <= '0;
      end else if (cmd.rdStep) begin
        if (rdCnt == 4'd0) begin
          rdBit <= aligned[15];
          shQ   <= {aligned[14:0], 1'b0};
          rdCnt <= wordLast;
        end else begin
          rdBit <= shQ[15];
          shQ   <= {shQ[14:0], 1'b0};
          rdCnt <= rdCnt - 4'd1;
          if (rdCnt == 4'd1) addrQ <= addrInc;
        end
      end
    end
  end

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uwire_pkg::*;
#(
  parameter int WORD_AW     = 10,
  parameter int PROG_CYCLES = 5000,
  parameter int BULK_CYCLES = 15000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  input  logic diIn,
  input  logic orgWide,
  input  logic progEnable,
  output logic doOut,
  output logic doOe
);

  dpCmd_t cmd;
  phase_t phase;
  logic   diBit, statusSel, busy, writeEnabled, rdBit;

  uwire_ctrl #(
    .WORD_AW(WORD_AW), .PROG_CYCLES(PROG_CYCLES), .BULK_CYCLES(BULK_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .diIn(diIn),
    .orgWide(orgWide), .progEnable(progEnable), .cmd(cmd), .diBit(diBit),
    .doOe(doOe), .statusSel(statusSel), .busy(busy),
    .writeEnabled(writeEnabled), .phase(phase)
  );

  uwire_dp #(.WORD_AW(WORD_AW)) u_dp (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .diBit(diBit),
    .cmd(cmd), .rdBit(rdBit)
  );

  assign doOut = statusSel ? ~busy : rdBit;

endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk
  import uwire_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   csIn,
  input logic   doOe,
  input logic   doOut,
  input logic   progEnable,
  input logic   busy,
  input logic   writeEnabled,
  input phase_t phase
);

  // R11
  released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csIn && !$past(csIn) && !$past(csIn, 2) && !$past(csIn, 3)) |-> !doOe);

  // R11
  busy_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && doOe) |-> !doOut);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (phase == PH_IDLE || phase == PH_DONE));

  // R4 R5
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(writeEnabled) && $past(progEnable)));

  // R4
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (writeEnabled != $past(writeEnabled)) |-> ($past(phase) == PH_ADDR));

endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .doOe(doOe), .doOut(doOut),
  .progEnable(progEnable), .busy(busy), .writeEnabled(writeEnabled), .phase(phase)
);

// File: tb/test_uwire_eeprom.sv
module test_uwire_eeprom;

  localparam int AW    = 4;
  localparam int PROG  = 400;
  localparam int BULK  = 900;
  localparam int WORDS = 16;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic org = 1'b1, pe = 1'b1;
  logic doOut, doOe;
  int   nTests = 0, nFail = 0;
  bit   finished = 1'b0;
  logic [15:0] model [WORDS];
  logic [15:0] rbuf [64];
  logic dummyOk, oeOk;
  int   cyc;
  bit   shown;

  always #4 clk = ~clk;

  uwire_eeprom #(.WORD_AW(AW), .PROG_CYCLES(PROG), .BULK_CYCLES(BULK)) i_uwire_eeprom (
    .clk(clk), .rstN(rstN), .csIn(cs), .sclkIn(sclk), .diIn(di),
    .orgWide(org), .progEnable(pe), .doOut(doOut), .doOe(doOe)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h1357) ^ 16'hA5C3);
  endfunction

  function automatic int addrW();
    return org ? AW : AW + 1;
  endfunction

  function automatic int dataW();
    return org ? 16 : 8;
  endfunction

  function automatic logic [15:0] extAddr(input logic [1:0] code);
    return 16'(code) << (addrW() - 2);
  endfunction

  function automatic logic [15:0] byteExp(input int b);
    return b[0] ? {8'h00, model[b / 2][15:8]} : {8'h00, model[b / 2][7:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic d);
    di = d;
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic csHigh();
    cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic csLow();
    cs = 1'b0;
    di = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [15:0] a, input int lead);
    csHigh();
    for (int i = 0; i < lead; i++) tick(1'b0);
    tick(1'b1);
    sendBits({14'b0, op}, 2);
    sendBits(a, addrW());
  endtask

  task automatic waitReady();
    cs = 1'b1;
    repeat (4) @(negedge clk);
    shown = doOe && !doOut;
    cyc = 0;
    while (!(doOe && doOut) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    tick(1'b1);
    csLow();
  endtask

  task automatic noStatus(input string req);
    csHigh();
    check(!doOe, req, 32'(doOe), 0);
    csLow();
  endtask

  task automatic readRun(input logic [15:0] a, input int n, input int lead);
    logic [15:0] w;
    sendCmd(2'b10, a, lead);
    dummyOk = doOe && !doOut;
    oeOk = 1'b1;
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < dataW(); b++) begin
        tick(1'b0);
        w = {w[14:0], doOut};
        oeOk = oeOk & doOe;
      end
      rbuf[k] = w;
    end
    csLow();
  endtask

  task automatic progCheck(input int limit);
    waitReady();
    check(shown, "R11 busy status 0", 32'(shown), 1);
    check(cyc >= limit - 40 && cyc <= limit, "R12 busy length", 32'(cyc), 32'(limit));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!doOe, "R11 reset released", 32'(doOe), 0);

    // R4: locked after reset
    sendCmd(2'b01, 16'd3, 0);
    sendBits(16'h1234, 16);
    csLow();
    noStatus("R4 locked after reset");

    // R2 unlock, then R7 erase-all
    sendCmd(2'b00, extAddr(2'b11), 0);
    csLow();
    sendCmd(2'b00, extAddr(2'b10), 0);
    csLow();
    progCheck(BULK);
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    readRun(16'd0, WORDS, 0);
    check(dummyOk, "R9 dummy zero", 32'(dummyOk), 1);
    for (int i = 0; i < WORDS; i++) check(rbuf[i] == 16'hFFFF, "R7 erase-all", 32'(rbuf[i]), 32'hFFFF);

    // R6 write sweep, 16-bit mode
    for (int a = 0; a < WORDS; a++) begin
      sendCmd(2'b01, 16'(a), 0);
      sendBits(pat(a), 16);
      csLow();
      progCheck(PROG);
      model[a] = pat(a);
    end
    csHigh();
    check(!doOe, "R11 status cleared", 32'(doOe), 0);
    csLow();
    for (int a = 0; a < WORDS; a++) begin
      readRun(16'(a), 1, 0);
      check(dummyOk, "R9 dummy zero", 32'(dummyOk), 1);
      check(rbuf[0] == model[a], "R6 R3 word read", 32'(rbuf[0]), 32'(model[a]));
    end
    check(!doOe, "R11 released on cs low", 32'(doOe), 0);

    // R10 sequential read with wrap
    readRun(16'd14, 4, 0);
    check(oeOk, "R10 continuous drive", 32'(oeOk), 1);
    for (int k = 0; k < 4; k++)
      check(rbuf[k] == model[(14 + k) % WORDS], "R10 wrap 16-bit", 32'(rbuf[k]), 32'(model[(14 + k) % WORDS]));

    // R3 byte mode
    org = 1'b0;
    readRun(16'd0, 2 * WORDS, 0);
    for (int b = 0; b < 2 * WORDS; b++)
      check(rbuf[b] == byteExp(b), "R3 byte lane", 32'(rbuf[b]), 32'(byteExp(b)));
    readRun(16'd30, 4, 0);
    for (int k = 0; k < 4; k++)
      check(rbuf[k] == byteExp((30 + k) % 32), "R10 wrap 8-bit", 32'(rbuf[k]), 32'(byteExp((30 + k) % 32)));
    sendCmd(2'b01, 16'd5, 0);
    sendBits(16'h003C, 8);
    csLow();
    progCheck(PROG);
    model[2][15:8] = 8'h3C;
    sendCmd(2'b11, 16'd8, 0);
    csLow();
    progCheck(PROG);
    model[4][7:0] = 8'hFF;
    org = 1'b1;
    readRun(16'd2, 1, 0);
    check(rbuf[0] == model[2], "R3 byte write lane", 32'(rbuf[0]), 32'(model[2]));
    readRun(16'd4, 1, 0);
    check(rbuf[0] == model[4], "R6 byte erase", 32'(rbuf[0]), 32'(model[4]));

    // R6 word erase
    sendCmd(2'b11, 16'd7, 0);
    csLow();
    progCheck(PROG);
    model[7] = 16'hFFFF;
    readRun(16'd7, 1, 0);
    check(rbuf[0] == 16'hFFFF, "R6 erase word", 32'(rbuf[0]), 32'hFFFF);

    // R8 truncated write
    sendCmd(2'b01, 16'd9, 0);
    sendBits(16'h0155, 10);
    csLow();
    noStatus("R8 truncated no status");
    readRun(16'd9, 1, 0);
    check(rbuf[0] == model[9], "R8 truncated discarded", 32'(rbuf[0]), 32'(model[9]));

    // R5 protect input
    pe = 1'b0;
    sendCmd(2'b01, 16'd1, 0);
    sendBits(16'h0000, 16);
    csLow();
    noStatus("R5 write blocked status");
    sendCmd(2'b00, extAddr(2'b10), 0);
    csLow();
    noStatus("R5 erase-all blocked status");
    pe = 1'b1;
    readRun(16'd0, 2, 0);
    check(rbuf[0] == model[0], "R5 word 0 kept", 32'(rbuf[0]), 32'(model[0]));
    check(rbuf[1] == model[1], "R5 word 1 kept", 32'(rbuf[1]), 32'(model[1]));

    // R12 frame ignored while busy
    sendCmd(2'b01, 16'd10, 0);
    sendBits(16'hBEEF, 16);
    csLow();
    model[10] = 16'hBEEF;
    sendCmd(2'b11, 16'd11, 0);
    csLow();
    waitReady();
    readRun(16'd10, 2, 0);
    check(rbuf[0] == 16'hBEEF, "R12 first write done", 32'(rbuf[0]), 32'hBEEF);
    check(rbuf[1] == model[11], "R12 erase during busy ignored", 32'(rbuf[1]), 32'(model[11]));

    // R7 write-all, both organizations
    sendCmd(2'b00, extAddr(2'b01), 0);
    sendBits(16'h5AA5, 16);
    csLow();
    progCheck(BULK);
    readRun(16'd0, WORDS, 0);
    for (int i = 0; i < WORDS; i++) check(rbuf[i] == 16'h5AA5, "R7 write-all 16", 32'(rbuf[i]), 32'h5AA5);
    org = 1'b0;
    sendCmd(2'b00, extAddr(2'b01), 0);
    sendBits(16'h00C3, 8);
    csLow();
    progCheck(BULK);
    org = 1'b1;
    readRun(16'd0, WORDS, 0);
    for (int i = 0; i < WORDS; i++) check(rbuf[i] == 16'hC3C3, "R7 write-all 8", 32'(rbuf[i]), 32'hC3C3);

    // R2 R4 lock, then write refused; read still works
    sendCmd(2'b00, extAddr(2'b00), 0);
    csLow();
    sendCmd(2'b01, 16'd6, 0);
    sendBits(16'h1111, 16);
    csLow();
    noStatus("R4 locked again");
    readRun(16'd6, 1, 0);
    check(rbuf[0] == 16'hC3C3, "R4 read while locked", 32'(rbuf[0]), 32'hC3C3);

    // R1 activity with cs low, then leading zeros before the start bit
    cs = 1'b0;
    for (int i = 0; i < 6; i++) tick(1'b1);
    check(!doOe, "R1 idle clocks", 32'(doOe), 0);
    readRun(16'd3, 1, 3);
    check(dummyOk, "R1 start after zeros", 32'(dummyOk), 1);
    check(rbuf[0] == 16'hC3C3, "R1 read after zeros", 32'(rbuf[0]), 32'hC3C3);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule